// File: doc/BRIEF.md
# SPI Slave Word Channel

This block is one serial peripheral channel working as the slave of an external SPI master. It uses mode 0 timing (clock idles low, data sampled on the rising edge) and sends the most significant bit first. The word length is a parameter between 4 and 32 bits. The serial clock, the active-low chip select and MOSI all pass through synchronisers into the system clock domain. All shifting is done from edges detected in that domain.

Software writes a transmit holding register and reads received words. The channel copies the holding register into the shift register at the start of every word, including when software has not written a new value since the previous word. A stale load like this raises an underflow flag, and the word is still sent.

- When a word finishes, the channel sets an end-of-transfer flag and places the word in a receive register.
- When the receive FIFO is enabled, finished words go into the FIFO instead. The end-of-transfer flag and the receive register are then left alone.
- A 2-bit mode input selects one of two behaviours. `00` is transmit-and-receive; `10` and `11` behave the same way. `01` is receive-only: MISO is held low and the transmit-empty and underflow interrupts are masked.

Top module: `spi_slave_chan`

## Requirements
- R1: When chip select is asserted, and after each completed word while it stays asserted, the transmit holding register is loaded into the shift register. In a transmit mode MISO then presents it MSB first, with one bit per serial clock rising edge.
- R2: If the holding register was not written since the previous load, the first rising edge of the word sets `uflow_flag`. The stale content is still transmitted unchanged.
- R3: After exactly WORD_W rising edges of the serial clock with chip select held low, the word sampled from MOSI (MSB first) is written to the receive register. In the same step `eot_flag` and `rx_avail` are set.
- R4: `xfer_mode` = 2'b01 (receive-only) holds MISO at 0. Every other encoding drives the shift-register MSB onto MISO while chip select is active. MISO is 0 while chip select is inactive.
- R5: In receive-only mode `irq_tx_empty` and `irq_underflow` are both 0. In the other modes:
  - `irq_tx_empty` equals `tx_empty`;
  - `irq_underflow` equals `uflow_flag`.
- R6: With `fifo_en` = 1, completed words are pushed into a receive FIFO and read in arrival order through `rx_rdata`/`rx_rd`. In this mode `eot_flag` is not set and the receive register keeps its value. `rx_rdata` shows the register again once `fifo_en` returns to 0.
- R7: Serial clock edges while chip select is high change nothing. Raising chip select part-way through a word discards the partial bits: no word completes, and the next word starts again at its first bit.
- R8: After reset:
  - MISO is 0;
  - `tx_empty` and `irq_tx_empty` are 1;
  - `rx_avail`, `eot_flag` and `uflow_flag` are 0.
- R9: `tx_wr` stores `tx_wdata` and clears `tx_empty`. Each load of the holding register into the shift register sets `tx_empty` again.
- R10: `stat_clr[0]` clears `eot_flag`, `stat_clr[1]` clears `uflow_flag`, and `rx_rd` clears `rx_avail` in register mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| xfer_mode | input | 2 | 00 transmit-and-receive, 01 receive-only, others as 00 |
| fifo_en | input | 1 | Route received words into the FIFO |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_wdata | input | WORD_W | Transmit word |
| rx_rd | input | 1 | Read strobe (pop in FIFO mode) |
| rx_rdata | output | WORD_W | Receive register or FIFO head |
| stat_clr | input | 2 | Clear strobes: bit 0 end-of-transfer, bit 1 underflow |
| tx_empty | output | 1 | Holding register consumed |
| rx_avail | output | 1 | Received data waiting |
| eot_flag | output | 1 | Sticky end-of-transfer |
| uflow_flag | output | 1 | Sticky underflow |
| irq_tx_empty | output | 1 | Transmit-empty interrupt request |
| irq_underflow | output | 1 | Underflow interrupt request |

## Verification
The assertions take the following for granted about the inputs:
- each serial clock level lasts several system clocks, so that every edge survives synchronisation as one distinct event;
- MOSI is stable across the synchronised rising edge;
- `xfer_mode` and `fifo_en` change only while chip select is inactive.

The bench's master model keeps every serial clock phase at eight system clocks. It changes MOSI only while the clock is low, and reprograms mode and FIFO selection only between transfers. It also gives at least eight system clocks between chip select changes and clock edges.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;

  typedef enum logic [1:0] {
    XM_TXRX   = 2'b00,
    XM_RXONLY = 2'b01
  } xfer_mode_e;

  // receive-only is the single encoding that silences the transmit side
  function automatic logic is_rx_only(input logic [1:0] mode);
    return mode == XM_RXONLY;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din[g]};
      end
      assign q[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine #(
  parameter int W  = 8,
  parameter int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_act_s,
  input  logic         sclk_s,
  input  logic         mosi_s,
  input  logic [W-1:0] tx_word,
  input  logic         tx_fresh,
  output logic         cs_active,
  output logic         load_pulse,
  output logic         word_done,
  output logic         uflow_pulse,
  output logic [W-1:0] rx_word,
  output logic         shift_msb,
  output logic [CW-1:0] bit_cnt
);
  localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

  function automatic logic [W-1:0] shift_in(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  logic [W-1:0] shreg;
  logic         stale;
  logic         cs_d, sclk_d;
  logic         cs_start, sclk_rise;

  assign cs_active   = cs_act_s;
  assign cs_start    = cs_act_s & ~cs_d;
  assign sclk_rise   = sclk_s & ~sclk_d;
  assign word_done   = cs_act_s & sclk_rise & (bit_cnt == LAST_BIT);
  assign uflow_pulse = cs_act_s & sclk_rise & (bit_cnt == '0) & stale;
  assign load_pulse  = cs_start | word_done;
  assign rx_word     = shift_in(shreg, mosi_s);
  assign shift_msb   = shreg[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d    <= 1'b0;
      sclk_d  <= 1'b0;
      shreg   <= '0;
      stale   <= 1'b0;
      bit_cnt <= '0;
    end else begin
      cs_d   <= cs_act_s;
      sclk_d <= sclk_s;
      if (load_pulse) begin
        shreg   <= tx_word;
        stale   <= ~tx_fresh;
        bit_cnt <= '0;
      end else if (cs_act_s && sclk_rise) begin
        shreg   <= shift_in(shreg, mosi_s);
        bit_cnt <= bit_cnt + 1'b1;
      end else if (!cs_act_s) begin
        bit_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign do_push = push && (cnt != (AW+1)'(DEPTH));
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/spi_slave_chan.sv
module spi_slave_chan
  import spi_chan_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FIFO_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic [1:0]        xfer_mode,
  input  logic              fifo_en,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_wdata,
  input  logic              rx_rd,
  output logic [WORD_W-1:0] rx_rdata,
  input  logic [1:0]        stat_clr,
  output logic              tx_empty,
  output logic              rx_avail,
  output logic              eot_flag,
  output logic              uflow_flag,
  output logic              irq_tx_empty,
  output logic              irq_underflow
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [2:0]        sync_q;
  logic              cs_active, load_pulse, word_done, uflow_pulse, shift_msb;
  logic [WORD_W-1:0] rx_word, fifo_dout, tx_hold, rx_reg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              tx_fresh, rx_valid, fifo_empty, rxo;

  spi_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({mosi, sclk, ~cs_n}), .q(sync_q)
  );

  spi_word_engine #(.W(WORD_W), .CW(CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .cs_act_s(sync_q[0]), .sclk_s(sync_q[1]), .mosi_s(sync_q[2]),
    .tx_word(tx_hold), .tx_fresh(tx_fresh),
    .cs_active(cs_active), .load_pulse(load_pulse), .word_done(word_done),
    .uflow_pulse(uflow_pulse), .rx_word(rx_word), .shift_msb(shift_msb),
    .bit_cnt(bit_cnt)
  );

  spi_rx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(word_done & fifo_en), .din(rx_word),
    .pop(rx_rd & fifo_en), .dout(fifo_dout), .empty(fifo_empty)
  );

  assign rxo           = is_rx_only(xfer_mode);
  assign miso          = cs_active & ~rxo & shift_msb;
  assign tx_empty      = ~tx_fresh;
  assign irq_tx_empty  = ~rxo & tx_empty;
  assign irq_underflow = ~rxo & uflow_flag;
  assign rx_rdata      = fifo_en ? fifo_dout : rx_reg;
  assign rx_avail      = fifo_en ? ~fifo_empty : rx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold    <= '0;
      tx_fresh   <= 1'b0;
      rx_reg     <= '0;
      rx_valid   <= 1'b0;
      eot_flag   <= 1'b0;
      uflow_flag <= 1'b0;
    end else begin
      if (tx_wr) begin
        tx_hold  <= tx_wdata;
        tx_fresh <= 1'b1;
      end else if (load_pulse) begin
        tx_fresh <= 1'b0;
      end

      if (word_done && !fifo_en) begin
        rx_reg   <= rx_word;
        rx_valid <= 1'b1;
      end else if (rx_rd && !fifo_en) begin
        rx_valid <= 1'b0;
      end

      if (word_done && !fifo_en) eot_flag <= 1'b1;
      else if (stat_clr[0])      eot_flag <= 1'b0;

      if (uflow_pulse)      uflow_flag <= 1'b1;
      else if (stat_clr[1]) uflow_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_slave_chan_chk.sv
module spi_slave_chan_chk #(
  parameter int W  = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    xfer_mode,
  input logic          fifo_en,
  input logic          miso,
  input logic          irq_tx_empty,
  input logic          irq_underflow,
  input logic          tx_wr,
  input logic          tx_empty,
  input logic          word_done,
  input logic          uflow_pulse,
  input logic          uflow_flag,
  input logic          eot_flag,
  input logic          rx_avail,
  input logic [W-1:0]  rx_reg,
  input logic          cs_active,
  input logic [CW-1:0] bit_cnt
);
  // R2
  uflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_pulse |=> uflow_flag);

  // R3
  eot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !fifo_en |=> eot_flag && rx_avail);

  // R4
  rxo_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_mode == 2'b01 |-> !miso);

  // R5
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_mode == 2'b01 |-> !irq_tx_empty && !irq_underflow);

  // R6
  fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && fifo_en && !eot_flag |=> $stable(rx_reg) && !eot_flag);

  // R7
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> bit_cnt == '0);

  // R9
  tx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_empty);
endmodule

bind spi_slave_chan spi_slave_chan_chk #(.W(WORD_W), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_mode(xfer_mode), .fifo_en(fifo_en),
  .miso(miso), .irq_tx_empty(irq_tx_empty), .irq_underflow(irq_underflow),
  .tx_wr(tx_wr), .tx_empty(tx_empty), .word_done(word_done),
  .uflow_pulse(uflow_pulse), .uflow_flag(uflow_flag), .eot_flag(eot_flag),
  .rx_avail(rx_avail), .rx_reg(rx_reg), .cs_active(cs_active), .bit_cnt(bit_cnt)
);

// File: tb/test_spi_slave_chan.sv
module test_spi_slave_chan;
  localparam int W = 8;
  localparam int HALF = 8;
  localparam int NVEC = 8;
  // {mode[1:0], write, tx_word[7:0], mosi_word[7:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {2'b00, 1'b1, 8'hA5, 8'h3C},
    {2'b00, 1'b0, 8'h00, 8'hC3},
    {2'b00, 1'b1, 8'h81, 8'h7E},
    {2'b01, 1'b1, 8'h55, 8'hF0},
    {2'b01, 1'b0, 8'h00, 8'h0F},
    {2'b00, 1'b0, 8'h00, 8'h99},
    {2'b11, 1'b1, 8'hFF, 8'h00},
    {2'b00, 1'b1, 8'h01, 8'h80}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
  logic [1:0] xfer_mode = 2'b00, stat_clr = 2'b00;
  logic fifo_en = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
  logic [W-1:0] tx_wdata = '0, rx_rdata;
  logic tx_empty, rx_avail, eot_flag, uflow_flag, irq_tx_empty, irq_underflow;

  int n_checks = 0, n_fail = 0;
  logic [W-1:0] got, got2, model_hold;

  always #5 clk = ~clk;

  spi_slave_chan #(.WORD_W(W)) i_spi_slave_chan (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .xfer_mode(xfer_mode), .fifo_en(fifo_en), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .stat_clr(stat_clr), .tx_empty(tx_empty),
    .rx_avail(rx_avail), .eot_flag(eot_flag), .uflow_flag(uflow_flag),
    .irq_tx_empty(irq_tx_empty), .irq_underflow(irq_underflow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_tx(input logic [W-1:0] d);
    tx_wdata = d; tx_wr = 1'b1; wait_clk(1); tx_wr = 1'b0; wait_clk(1);
  endtask

  task automatic read_rx();
    rx_rd = 1'b1; wait_clk(1); rx_rd = 1'b0; wait_clk(1);
  endtask

  task automatic clear_flags();
    stat_clr = 2'b11; wait_clk(1); stat_clr = 2'b00; wait_clk(1);
  endtask

  task automatic cs_on();
    cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic cs_off();
    wait_clk(HALF); cs_n = 1'b1; wait_clk(2 * HALF);
  endtask

  // behavioural mode-0 master: drive while low, sample on the rising edge
  task automatic shift_bits(input logic [W-1:0] dout, input int nbits, output logic [W-1:0] din);
    din = '0;
    for (int i = W - 1; i >= W - nbits; i--) begin
      mosi = dout[i];
      wait_clk(HALF);
      sclk = 1'b1;
      din[i] = miso;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    model_hold = '0;
    wait_clk(4);
    // R8 reset state
    check("R8 miso", miso, 0);
    check("R8 tx_empty", tx_empty, 1);
    check("R8 irq_tx_empty", irq_tx_empty, 1);
    check("R8 rx_avail", rx_avail, 0);
    check("R8 eot", eot_flag, 0);
    check("R8 uflow", uflow_flag, 0);
    rst_n = 1'b1;
    wait_clk(4);
    check("R8 after release miso", miso, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] md;
      logic wr;
      logic [W-1:0] txw, mw;
      {md, wr, txw, mw} = VEC[v];
      xfer_mode = md;
      clear_flags();
      if (wr) begin
        write_tx(txw);
        model_hold = txw;
        check("R9 tx_empty after write", tx_empty, 0);
      end
      cs_on();
      shift_bits(mw, W, got);
      cs_off();
      check("R1/R4 master received", got, (md == 2'b01) ? '0 : model_hold);
      check("R3 rx word", rx_rdata, mw);
      check("R3 eot", eot_flag, 1);
      check("R3 rx_avail", rx_avail, 1);
      check("R2 underflow flag", uflow_flag, !wr);
      check("R5 irq_underflow", irq_underflow, (md != 2'b01) && !wr);
      check("R9 tx_empty after load", tx_empty, 1);
      check("R5 irq_tx_empty", irq_tx_empty, md != 2'b01);
      read_rx();
      check("R10 rx_avail cleared", rx_avail, 0);
    end
    xfer_mode = 2'b00;

    // R10 clear strobes individually
    stat_clr = 2'b01; wait_clk(1); stat_clr = 2'b00; wait_clk(1);
    check("R10 eot cleared", eot_flag, 0);
    check("R10 uflow untouched by bit0", uflow_flag, 0);

    // R7 clock edges with chip select high
    for (int k = 0; k < 10; k++) begin
      sclk = 1'b1; wait_clk(HALF); sclk = 1'b0; wait_clk(HALF);
    end
    check("R7 no eot while deselected", eot_flag, 0);
    check("R7 no data while deselected", rx_avail, 0);
    check("R7 rx register unchanged", rx_rdata, 8'h80);

    // R7 aborted partial word then a full word
    write_tx(8'h96);
    cs_on();
    shift_bits(8'hE0, 3, got);
    cs_off();
    check("R7 partial word no eot", eot_flag, 0);
    write_tx(8'h96);
    cs_on();
    shift_bits(8'h5A, W, got);
    cs_off();
    check("R7 word after abort", rx_rdata, 8'h5A);
    check("R1 word after abort tx", got, 8'h96);
    read_rx();
    clear_flags();

    // R6 FIFO mode, two words in one select, second one stale
    fifo_en = 1'b1;
    write_tx(8'h3C);
    cs_on();
    shift_bits(8'h11, W, got);
    shift_bits(8'h22, W, got2);
    cs_off();
    check("R1 burst first", got, 8'h3C);
    check("R2 burst stale resend", got2, 8'h3C);
    check("R2 burst underflow", uflow_flag, 1);
    check("R6 no eot in fifo mode", eot_flag, 0);
    check("R6 fifo has data", rx_avail, 1);
    check("R6 fifo head first", rx_rdata, 8'h11);
    read_rx();
    check("R6 fifo head second", rx_rdata, 8'h22);
    read_rx();
    check("R6 fifo drained", rx_avail, 0);
    fifo_en = 1'b0;
    wait_clk(1);
    check("R6 register kept", rx_rdata, 8'h5A);

    // R5 receive-only masks transmit-empty request
    xfer_mode = 2'b01; wait_clk(1);
    check("R5 tx_empty raw", tx_empty, 1);
    check("R5 irq_tx_empty masked", irq_tx_empty, 0);
    check("R5 irq_underflow masked", irq_underflow, 0);
    xfer_mode = 2'b00; wait_clk(1);
    check("R5 irq_underflow unmasked", irq_underflow, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule